// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms a 20-bit physical byte address from a 16-bit offset and one of four 16-bit segment bases. The base is shifted left by four bits before the offset is added, so every segment begins on a 16-byte boundary and covers 64 KiB from there. The sum is taken modulo 2^20.

The base is never named by the requester. It follows from the kind of access. Instruction fetches use the code segment. Stack accesses use the stack segment. Ordinary data uses the data segment, unless a per-request override selects the extra segment. Alternate-data accesses always use the extra segment. Each segment register has its own load strobe and value. A request is captured on a clock edge, and the address appears one cycle later with a valid flag.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, `addr_valid` is 0, `addr_out` is 0, and all four segment registers read as 0.
- R2: A request accepted on one clock edge produces `addr_valid`=1 and `addr_out` = ((selected segment << 4) + `req_offset`) mod 2^20 after that edge.
- R3: `req_kind`=2'b00 (instruction fetch) uses the code segment.
- R4: `req_kind`=2'b11 (stack) uses the stack segment.
- R5: `req_kind`=2'b01 (data) uses the data segment when `req_override`=0 and the extra segment when `req_override`=1.
- R6: `req_kind`=2'b10 (alternate data) uses the extra segment whatever the value of `req_override`.
- R7: `req_override` has no effect on fetch or stack accesses.
- R8: A sum above 20 bits wraps, and only the low 20 bits are kept.
- R9: A segment load takes effect on the next clock. A request in the same cycle as the load uses the old value.
- R10: In a cycle with no request, `addr_valid` goes to 0 on the next edge and `addr_out` keeps its last value.
- R11: Loading one segment register leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_ld | input | 1 | Load strobe for the code segment |
| code_val | input | 16 | New code segment value |
| data_ld | input | 1 | Load strobe for the data segment |
| data_val | input | 16 | New data segment value |
| stack_ld | input | 1 | Load strobe for the stack segment |
| stack_val | input | 16 | New stack segment value |
| extra_ld | input | 1 | Load strobe for the extra segment |
| extra_val | input | 16 | New extra segment value |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | Access kind: 00 fetch, 01 data, 10 alternate data, 11 stack |
| req_override | input | 1 | For data accesses, selects the extra segment |
| req_offset | input | 16 | Offset within the segment |
| addr_valid | output | 1 | Registered flag: the address is valid |
| addr_out | output | 20 | Registered physical address |

## Verification
The assertions check the following on every cycle:
- the segment the multiplexer picks for each access kind and override value;
- that the registered address equals the shifted base plus the offset from the cycle before;
- the one-cycle latency of the valid flag;
- that the address holds when no request is present;
- that a load becomes visible one cycle after its strobe.

Some behaviours are visible only through the bench's end-to-end scenarios, which compare each result against values worked out from the requirements:
- the reset values;
- the wrap of sums above 2^20 at the boundary;
- a load and a request in the same cycle;
- the independence of the four registers.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_DATA  = 2'b01,
    ACC_ALT   = 2'b10,
    ACC_STACK = 2'b11
  } acc_kind_e;

  localparam int unsigned NUM_SEG   = 4;
  localparam int unsigned SEG_CODE  = 0;
  localparam int unsigned SEG_DATA  = 1;
  localparam int unsigned SEG_STACK = 2;
  localparam int unsigned SEG_EXTRA = 3;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned NSEG  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSEG-1:0]            ld_en,
  input  logic [NSEG-1:0][SEG_W-1:0] ld_val,
  output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic [SEG_W-1:0] seg_d;

    always_comb begin
      seg_d = seg_q[i];
      if (ld_en[i]) seg_d = ld_val[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[i] <= '0;
      else        seg_q[i] <= seg_d;
    end
  end
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned NSEG  = 4
) (
  input  logic [1:0]                 kind,
  input  logic                       ovr,
  input  logic [NSEG-1:0][SEG_W-1:0] seg_q,
  output logic [SEG_W-1:0]           sel
);
  acc_kind_e kind_e;
  assign kind_e = acc_kind_e'(kind);

  always_comb begin
    unique case (kind_e)
      ACC_FETCH: sel = seg_q[SEG_CODE];
      ACC_DATA:  sel = ovr ? seg_q[SEG_EXTRA] : seg_q[SEG_DATA];
      ACC_ALT:   sel = seg_q[SEG_EXTRA];
      ACC_STACK: sel = seg_q[SEG_STACK];
      default:   sel = seg_q[SEG_CODE];
    endcase
  end
endmodule

// File: rtl/addr_sum.sv
module addr_sum #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned BASE_W = SEG_W + SHIFT;

  logic [BASE_W-1:0] base;
  assign base = {seg, {SHIFT{1'b0}}};
  // The sum is truncated to ADDR_W bits, which gives the modulo wrap.
  assign addr = base[ADDR_W-1:0] + ADDR_W'(ofs);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     code_ld,
  input  logic [SEG_W-1:0]         code_val,
  input  logic                     data_ld,
  input  logic [SEG_W-1:0]         data_val,
  input  logic                     stack_ld,
  input  logic [SEG_W-1:0]         stack_val,
  input  logic                     extra_ld,
  input  logic [SEG_W-1:0]         extra_val,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic                     req_override,
  input  logic [OFS_W-1:0]         req_offset,
  output logic                     addr_valid,
  output logic [OFS_W+SHIFT-1:0]   addr_out
);
  localparam int unsigned ADDR_W = OFS_W + SHIFT;

  // Reset is asserted asynchronously and released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_SEG-1:0]            ld_en;
  logic [NUM_SEG-1:0][SEG_W-1:0] ld_val;
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]              sel_seg;
  logic [ADDR_W-1:0]             sum;

  always_comb begin
    ld_en             = '0;
    ld_en[SEG_CODE]   = code_ld;
    ld_en[SEG_DATA]   = data_ld;
    ld_en[SEG_STACK]  = stack_ld;
    ld_en[SEG_EXTRA]  = extra_ld;
    ld_val            = '0;
    ld_val[SEG_CODE]  = code_val;
    ld_val[SEG_DATA]  = data_val;
    ld_val[SEG_STACK] = stack_val;
    ld_val[SEG_EXTRA] = extra_val;
  end

  seg_bank #(.SEG_W(SEG_W), .NSEG(NUM_SEG)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .ld_en(ld_en), .ld_val(ld_val), .seg_q(seg_q)
  );

  seg_pick #(.SEG_W(SEG_W), .NSEG(NUM_SEG)) u_pick (
    .kind(req_kind), .ovr(req_override), .seg_q(seg_q), .sel(sel_seg)
  );

  addr_sum #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_sum (
    .seg(sel_seg), .ofs(req_offset), .addr(sum)
  );

  // Output stage: next-state logic, then the register.
  logic              vld_d;
  logic [ADDR_W-1:0] addr_d;
  always_comb begin
    vld_d  = req_valid;
    addr_d = addr_out;
    if (req_valid) addr_d = sum;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= vld_d;
      addr_out   <= addr_d;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [1:0]              req_kind,
  input logic                    req_override,
  input logic [OFS_W-1:0]        req_offset,
  input logic                    code_ld,
  input logic [SEG_W-1:0]        code_val,
  input logic [3:0][SEG_W-1:0]   segs,
  input logic [SEG_W-1:0]        sel_seg,
  input logic                    addr_valid,
  input logic [ADDR_W-1:0]       addr_out
);
  logic [ADDR_W-1:0] exp_c;
  assign exp_c = ADDR_W'({sel_seg, {SHIFT{1'b0}}}) + ADDR_W'(req_offset);

  p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (addr_valid && addr_out == $past(exp_c)));
  p_fetch_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b00) |-> sel_seg == segs[0]);
  p_stack_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b11) |-> sel_seg == segs[2]);
  p_data_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b01) |-> sel_seg == (req_override ? segs[3] : segs[1]));
  p_alt_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b10) |-> sel_seg == segs[3]);
  p_code_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    code_ld |=> segs[0] == $past(code_val));
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(addr_out));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_override(req_override), .req_offset(req_offset), .code_ld(code_ld),
  .code_val(code_val), .segs(seg_q), .sel_seg(sel_seg),
  .addr_valid(addr_valid), .addr_out(addr_out)
);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        code_ld, data_ld, stack_ld, extra_ld;
  logic [15:0] code_val, data_val, stack_val, extra_val;
  logic        req_valid, req_override;
  logic [1:0]  req_kind;
  logic [15:0] req_offset;
  logic        addr_valid;
  logic [19:0] addr_out;

  always #4 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .code_ld(code_ld), .code_val(code_val), .data_ld(data_ld), .data_val(data_val),
    .stack_ld(stack_ld), .stack_val(stack_val), .extra_ld(extra_ld), .extra_val(extra_val),
    .req_valid(req_valid), .req_kind(req_kind), .req_override(req_override),
    .req_offset(req_offset), .addr_valid(addr_valid), .addr_out(addr_out)
  );

  typedef struct { logic [19:0] addr; string tag; } exp_t;
  exp_t        sb[$];
  int          checks = 0, errors = 0;
  logic [15:0] shadow[4];
  logic [19:0] last_addr;
  bit          mon_en = 0, done = 0;

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] model(input logic [1:0] kind, input bit ovr, input logic [15:0] ofs);
    logic [15:0] s;
    case (kind)
      2'b00: s = shadow[0];
      2'b01: s = ovr ? shadow[3] : shadow[1];
      2'b10: s = shadow[3];
      default: s = shadow[2];
    endcase
    return {s, 4'h0} + {4'h0, ofs};
  endfunction

  // Driver: called at a falling edge. idx 0 code, 1 data, 2 stack, 3 extra; -1 means no load.
  task automatic cycle(input int idx, input logic [15:0] v, input bit req,
                       input logic [1:0] kind, input bit ovr, input logic [15:0] ofs, input string tag);
    exp_t e;
    code_ld = 0; data_ld = 0; stack_ld = 0; extra_ld = 0;
    code_val = v; data_val = v; stack_val = v; extra_val = v;
    case (idx)
      0: code_ld = 1;
      1: data_ld = 1;
      2: stack_ld = 1;
      3: extra_ld = 1;
      default: ;
    endcase
    req_valid = req; req_kind = kind; req_override = ovr; req_offset = ofs;
    if (req) begin
      e.addr = model(kind, ovr, ofs);   // uses pre-load segment values (R9)
      e.tag  = tag;
      sb.push_back(e);
    end
    if (idx >= 0) shadow[idx] = v;
    @(negedge clk);
  endtask

  // Monitor: compares results, and checks the hold behaviour on idle cycles.
  always @(negedge clk) begin
    if (mon_en) begin
      if (addr_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected valid", addr_out, last_addr);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(addr_out === e.addr, e.tag, addr_out, e.addr);
          last_addr = e.addr;
        end
      end else begin
        check(addr_out === last_addr, "R10 hold", addr_out, last_addr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    rst_n = 0;
    code_ld = 0; data_ld = 0; stack_ld = 0; extra_ld = 0;
    code_val = 0; data_val = 0; stack_val = 0; extra_val = 0;
    req_valid = 0; req_kind = 0; req_override = 0; req_offset = 0;
    repeat (3) @(negedge clk);
    check(addr_valid === 1'b0, "R1 valid", {19'd0, addr_valid}, 20'd0);
    check(addr_out === 20'd0, "R1 addr", addr_out, 20'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    last_addr = '0;
    mon_en = 1;

    cycle(-1, 0, 1, 2'b00, 0, 16'h1234, "R1 zero segment");
    cycle(-1, 0, 1, 2'b11, 0, 16'h0042, "R1 zero stack");
    cycle(0, 16'h1000, 1, 2'b00, 0, 16'h0010, "R9 same-cycle old value");
    cycle(-1, 0, 1, 2'b00, 0, 16'h0010, "R3 fetch new code");
    cycle(1, 16'h2000, 0, 2'b00, 0, 16'h0, "");
    cycle(2, 16'h3000, 0, 2'b00, 0, 16'h0, "");
    cycle(3, 16'h4000, 0, 2'b00, 0, 16'h0, "");
    cycle(-1, 0, 1, 2'b00, 0, 16'h0020, "R11 code kept");
    cycle(-1, 0, 1, 2'b01, 0, 16'h0004, "R5 data default");
    cycle(-1, 0, 1, 2'b01, 1, 16'h0004, "R5 data override");
    cycle(-1, 0, 1, 2'b10, 0, 16'h0100, "R6 alt");
    cycle(-1, 0, 1, 2'b10, 1, 16'h0101, "R6 alt override");
    cycle(-1, 0, 1, 2'b11, 0, 16'hFFFE, "R4 stack");
    cycle(-1, 0, 1, 2'b11, 1, 16'h0008, "R7 stack override");
    cycle(-1, 0, 1, 2'b00, 1, 16'h0008, "R7 fetch override");
    cycle(-1, 0, 0, 2'b00, 0, 16'h0, "");
    cycle(-1, 0, 0, 2'b01, 1, 16'hAAAA, "");
    cycle(0, 16'hFFFF, 1, 2'b01, 0, 16'h0001, "R2 data during code load");
    cycle(-1, 0, 1, 2'b00, 0, 16'h0020, "R8 wrap fetch");
    cycle(1, 16'hFFF0, 0, 2'b00, 0, 16'h0, "");
    cycle(-1, 0, 1, 2'b01, 0, 16'h1000, "R8 wrap data");
    cycle(2, 16'hF000, 1, 2'b11, 0, 16'hFFFF, "R9 stack old");
    cycle(-1, 0, 1, 2'b11, 0, 16'hFFFF, "R2 top of space");
    cycle(-1, 0, 1, 2'b10, 0, 16'h0000, "R11 extra kept");
    for (int k = 0; k < 4; k++) cycle(-1, 0, 1, 2'(k), 1'(k), 16'(k * 16'h1111), "R2 sweep");
    repeat (4) cycle(-1, 0, 0, 2'b00, 0, 16'h0, "");

    mon_en = 0;
    check(sb.size() == 0, "R2 missing results", 20'(sb.size()), 20'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule